// File: doc/BRIEF.md
# Vector Load/Store Address Generator

This block turns one vector memory instruction into a stream of effective addresses, one for each element from 0 up to the vector length minus one. A single start pulse captures the base register value, the immediate or stride operand, the addressing mode, the element widths and the vector length. The block then offers one address per cycle on a valid/ready handshake. Each address is tagged with its element number. A one-cycle done pulse marks the end of the stream.

There are three addressing modes. Unit stride walks contiguous memory from the base plus the immediate, stepping by the operation size. Element stride steps by a stride operand that has been narrowed to the element width. Indexed mode adds a per-element offset to the base. The offset is taken from a preloaded index array, narrowed to the element width, and then widened either with or without its sign. The base operand is always used at full width. The index array must stay stable while the block is issuing addresses.

Top module: `vldst_agen`

## Requirements
- R1: After reset, `agu_valid` and `agu_done` are low.
- R2: Unit stride (`idx_mode`=0, `str_mode`=0): element i gets address base + imm + i*B. B is set by `op_sz`: 00=8, 01=4, 10=2, 11=1 bytes.
- R3: Element stride (`idx_mode`=0, `str_mode`=1): element i gets address base + i*S. S is the stride operand cut to the width given by `ew` (00=64, 01=32, 10=16, 11=8 bits) and zero-extended, so this narrowing is always unsigned.
- R4: Indexed (`idx_mode`=1): element i gets address base + X. X is `idx_vec[i]` cut to the `ew` width. X is sign-extended when `sgn_idx`=1 and zero-extended when it is 0.
- R5: All 64 bits of the base operand take part in every mode, whatever the value of `ew`.
- R6: Element 0 is offered in the cycle after start is taken. Elements come in rising order, one per accepted handshake. While ready is low, the offered element and address hold.
- R7: `agu_done` is high for exactly one cycle, in the cycle after the last element is accepted. It is never high together with `agu_valid`.
- R8: With a vector length of 0, `agu_done` pulses in the cycle after start and no address is offered.
- R9: A vector length above MAX_VL is treated as MAX_VL.
- R10: A start pulse that arrives while a stream is active or its done pulse is showing is ignored. The active stream is not changed by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new address stream |
| idx_mode | input | 1 | 1 selects indexed addressing |
| str_mode | input | 1 | When not indexed, 0 selects unit stride and 1 selects element stride |
| sgn_idx | input | 1 | Sign-extend the narrowed index (indexed mode only) |
| ew | input | 2 | Element width code for the index or stride: 00=64, 01=32, 10=16, 11=8 bits |
| op_sz | input | 2 | Access size code for unit stride: 00=8, 01=4, 10=2, 11=1 bytes |
| vl | input | VLW | Vector length |
| base | input | XLEN | Base register value |
| imm_str | input | XLEN | Immediate (unit stride) or stride (element stride) |
| idx_vec | input | MAX_VL*XLEN | Preloaded index offsets, one per element |
| agu_valid | output | 1 | Address offered |
| agu_ready | input | 1 | Consumer takes the address |
| agu_ea | output | XLEN | Effective address |
| agu_elem | output | VLW | Element number of the offered address |
| agu_done | output | 1 | One-cycle end-of-stream pulse |

## Verification
The bench drives start at a falling edge. At the next falling edge, after one clock edge, element 0 must already be on the outputs, or for a zero length the done pulse must be there; the bench checks that exact cycle. After that, each handshake is judged at the falling edge before the rising edge that completes it, using the ready value the monitor has just driven. The done pulse is expected one cycle after the final handshake, and the expected queue must be empty when it appears. A stall window and a second start pulse during an active stream are used to show that held outputs stay put and that the extra start changes nothing.

// File: rtl/vagen_pkg.sv
package vagen_pkg;
    typedef enum logic [1:0] {
        EW_64 = 2'b00,
        EW_32 = 2'b01,
        EW_16 = 2'b10,
        EW_8  = 2'b11
    } ew_e;

    // Byte count of an access for a given size code
    function automatic logic [3:0] size_bytes(input logic [1:0] code);
        case (code)
            2'b00:   size_bytes = 4'd8;
            2'b01:   size_bytes = 4'd4;
            2'b10:   size_bytes = 4'd2;
            default: size_bytes = 4'd1;
        endcase
    endfunction
endpackage

// File: rtl/vagen_ext.sv
// Narrow an operand to the element width, then widen it back to XLEN
module vagen_ext #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] src,
    input  logic [1:0]      ew,
    input  logic            sgn,
    output logic [XLEN-1:0] dst
);
    import vagen_pkg::*;

    always_comb begin
        case (ew_e'(ew))
            EW_32:   dst = {{(XLEN-32){sgn & src[31]}}, src[31:0]};
            EW_16:   dst = {{(XLEN-16){sgn & src[15]}}, src[15:0]};
            EW_8:    dst = {{(XLEN-8){sgn & src[7]}},   src[7:0]};
            default: dst = src;
        endcase
    end
endmodule

// File: rtl/vagen_step.sv
// Unit-stride address increment
module vagen_step #(
    parameter int XLEN = 64
) (
    input  logic [1:0]      op_sz,
    output logic [XLEN-1:0] step
);
    import vagen_pkg::*;

    always_comb step = XLEN'(size_bytes(op_sz));
endmodule

// File: rtl/vldst_agen.sv
module vldst_agen #(
    parameter int XLEN   = 64,
    parameter int MAX_VL = 8,
    localparam int VLW   = $clog2(MAX_VL + 1),
    localparam int IXW   = $clog2(MAX_VL)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        idx_mode,
    input  logic                        str_mode,
    input  logic                        sgn_idx,
    input  logic [1:0]                  ew,
    input  logic [1:0]                  op_sz,
    input  logic [VLW-1:0]              vl,
    input  logic [XLEN-1:0]             base,
    input  logic [XLEN-1:0]             imm_str,
    input  logic [MAX_VL-1:0][XLEN-1:0] idx_vec,
    output logic                        agu_valid,
    input  logic                        agu_ready,
    output logic [XLEN-1:0]             agu_ea,
    output logic [VLW-1:0]              agu_elem,
    output logic                        agu_done
);
    typedef struct packed {
        logic            valid;
        logic            done;
        logic            indexed;
        logic            sgn;
        logic [1:0]      ew;
        logic [VLW-1:0]  elem;
        logic [VLW-1:0]  last;
        logic [XLEN-1:0] base;
        logic [XLEN-1:0] acc;
        logic [XLEN-1:0] step;
    } agu_st_t;

    agu_st_t st_d, st_q;

    logic [XLEN-1:0] stride_ext;
    logic [XLEN-1:0] unit_step;
    logic [XLEN-1:0] idx_ext;
    logic [VLW-1:0]  vl_eff;
    logic            take_start;

    // Stride narrowing is always unsigned
    vagen_ext #(.XLEN(XLEN)) u_stride_ext (
        .src (imm_str),
        .ew  (ew),
        .sgn (1'b0),
        .dst (stride_ext)
    );

    vagen_step #(.XLEN(XLEN)) u_step (
        .op_sz (op_sz),
        .step  (unit_step)
    );

    vagen_ext #(.XLEN(XLEN)) u_idx_ext (
        .src (idx_vec[st_q.elem[IXW-1:0]]),
        .ew  (st_q.ew),
        .sgn (st_q.sgn),
        .dst (idx_ext)
    );

    always_comb begin
        vl_eff     = (vl > VLW'(MAX_VL)) ? VLW'(MAX_VL) : vl;
        take_start = start && !st_q.valid && !st_q.done;

        st_d      = st_q;
        st_d.done = 1'b0;

        if (take_start) begin
            st_d.indexed = idx_mode;
            st_d.sgn     = sgn_idx;
            st_d.ew      = ew;
            st_d.base    = base;
            st_d.elem    = '0;
            st_d.last    = vl_eff - VLW'(1);
            st_d.acc     = (idx_mode || str_mode) ? base : base + imm_str;
            st_d.step    = str_mode ? stride_ext : unit_step;
            st_d.valid   = (vl_eff != '0);
            st_d.done    = (vl_eff == '0);
        end else if (st_q.valid && agu_ready) begin
            if (st_q.elem == st_q.last) begin
                st_d.valid = 1'b0;
                st_d.done  = 1'b1;
            end else begin
                st_d.elem = st_q.elem + VLW'(1);
                st_d.acc  = st_q.acc + st_q.step;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign agu_valid = st_q.valid;
    assign agu_done  = st_q.done;
    assign agu_elem  = st_q.elem;
    assign agu_ea    = st_q.indexed ? (st_q.base + idx_ext) : st_q.acc;
endmodule

// File: rtl/vldst_agen_chk.sv
module vldst_agen_chk #(
    parameter int XLEN   = 64,
    parameter int MAX_VL = 8,
    localparam int VLW   = $clog2(MAX_VL + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            agu_valid,
    input logic            agu_ready,
    input logic [XLEN-1:0] agu_ea,
    input logic [VLW-1:0]  agu_elem,
    input logic            agu_done
);
    // R1
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> !agu_valid && !agu_done);

    // R6
    p_hold_on_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        agu_valid && !agu_ready |=> agu_valid && $stable(agu_elem) && $stable(agu_ea));

    // R6
    p_elem_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
        agu_valid && agu_ready |=>
            (agu_valid && agu_elem == $past(agu_elem) + VLW'(1)) || (!agu_valid && agu_done));

    // R6
    p_first_elem_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(agu_valid) |-> agu_elem == '0);

    // R7
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        agu_done |=> !agu_done);

    // R7
    p_done_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(agu_valid && agu_done));

    // R9
    p_elem_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        agu_valid |-> agu_elem < VLW'(MAX_VL));
endmodule

bind vldst_agen vldst_agen_chk #(.XLEN(XLEN), .MAX_VL(MAX_VL)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .agu_valid (agu_valid),
    .agu_ready (agu_ready),
    .agu_ea    (agu_ea),
    .agu_elem  (agu_elem),
    .agu_done  (agu_done)
);

// File: tb/vldst_agen_tb_top.sv
module vldst_agen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN   = 64;
    localparam int MAX_VL = 8;
    localparam int VLW    = $clog2(MAX_VL + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic idx_mode = 1'b0, str_mode = 1'b0, sgn_idx = 1'b0;
    logic [1:0] ew = 2'b00, op_sz = 2'b00;
    logic [VLW-1:0] vl = '0;
    logic [XLEN-1:0] base = '0, imm_str = '0;
    logic [MAX_VL-1:0][XLEN-1:0] idx_vec = '0;
    logic agu_valid, agu_ready, agu_done;
    logic [XLEN-1:0] agu_ea;
    logic [VLW-1:0] agu_elem;

    int checks = 0;
    int fails = 0;
    int done_seen = 0;
    bit rdy_always = 1'b1;
    bit rdy_stall = 1'b0;
    logic [7:0] lfsr = 8'hA5;
    string cur_req = "R2";

    logic [XLEN-1:0] exp_ea_q[$];
    int              exp_el_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    vldst_agen #(.XLEN(XLEN), .MAX_VL(MAX_VL)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .idx_mode(idx_mode),
        .str_mode(str_mode), .sgn_idx(sgn_idx), .ew(ew), .op_sz(op_sz),
        .vl(vl), .base(base), .imm_str(imm_str), .idx_vec(idx_vec),
        .agu_valid(agu_valid), .agu_ready(agu_ready), .agu_ea(agu_ea),
        .agu_elem(agu_elem), .agu_done(agu_done)
    );

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] narrow(input logic [63:0] v, input logic [1:0] w,
                                           input bit s);
        case (w)
            2'b01: return s ? {{32{v[31]}}, v[31:0]} : {32'h0, v[31:0]};
            2'b10: return s ? {{48{v[15]}}, v[15:0]} : {48'h0, v[15:0]};
            2'b11: return s ? {{56{v[7]}}, v[7:0]} : {56'h0, v[7:0]};
            default: return v;
        endcase
    endfunction

    function automatic logic [63:0] ref_ea(input int i, input bit im, input bit sm,
        input bit sg, input logic [1:0] w, input logic [1:0] osz,
        input logic [63:0] b, input logic [63:0] is,
        input logic [MAX_VL-1:0][63:0] iv);
        logic [63:0] bytes;
        bytes = (osz == 2'b00) ? 64'd8 : (osz == 2'b01) ? 64'd4 : (osz == 2'b10) ? 64'd2 : 64'd1;
        if (im) return b + narrow(iv[i], w, sg);
        if (sm) return b + 64'(i) * narrow(is, w, 1'b0);
        return b + is + 64'(i) * bytes;
    endfunction

    // Monitor: drive ready, compare each handshake, watch done
    always @(negedge clk) begin
        if (rst_n) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            agu_ready = rdy_stall ? 1'b0 : (rdy_always ? 1'b1 : lfsr[0]);
            if (agu_valid && agu_ready) begin
                if (exp_ea_q.size() == 0) begin
                    check(1'b0, cur_req, "unexpected address", agu_ea, 64'h0);
                end else begin
                    logic [63:0] e;
                    int el;
                    e  = exp_ea_q.pop_front();
                    el = exp_el_q.pop_front();
                    check(agu_ea == e, cur_req, "address", agu_ea, e);
                    check(int'(agu_elem) == el, "R6", "element number",
                          64'(agu_elem), 64'(el));
                end
            end
            if (agu_done) begin
                done_seen++;
                check(exp_ea_q.size() == 0, "R7", "done with items pending",
                      64'(exp_ea_q.size()), 64'h0);
                check(!agu_valid, "R7", "valid with done", 64'(agu_valid), 64'h0);
            end
        end else begin
            agu_ready = 1'b0;
        end
    end

    task automatic run_op(input string req, input bit im, input bit sm, input bit sg,
        input logic [1:0] w, input logic [1:0] osz, input int n,
        input logic [63:0] b, input logic [63:0] is, input bit poke);
        int eff;
        int d0;
        int t;
        eff = (n > MAX_VL) ? MAX_VL : n;
        cur_req = req;
        for (int i = 0; i < eff; i++) begin
            exp_ea_q.push_back(ref_ea(i, im, sm, sg, w, osz, b, is, idx_vec));
            exp_el_q.push_back(i);
        end
        d0 = done_seen;
        @(negedge clk);
        idx_mode = im; str_mode = sm; sgn_idx = sg; ew = w; op_sz = osz;
        vl = VLW'(n); base = b; imm_str = is; start = 1'b1;
        if (poke) rdy_stall = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (eff == 0) begin
            check(agu_done && !agu_valid, "R8", "zero-length done timing",
                  {62'h0, agu_done, agu_valid}, 64'h2);
        end else begin
            check(agu_valid && agu_elem == '0, "R6", "first element timing",
                  {59'h0, agu_elem, agu_valid}, 64'h1);
        end
        if (poke) begin
            // R10: second start during the stream with other operands
            @(negedge clk);
            base = 64'hDEAD_0000_0000_0000; vl = VLW'(2); str_mode = ~sm;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(agu_valid && agu_elem == '0, "R10", "stream kept after stray start",
                  {59'h0, agu_elem, agu_valid}, 64'h1);
            rdy_stall = 1'b0;
        end
        t = 0;
        while (done_seen == d0 && t < 200) begin
            @(negedge clk);
            t++;
        end
        check(done_seen == d0 + 1, req, "done pulse count", 64'(done_seen - d0), 64'h1);
        @(negedge clk);
        check(!agu_done, "R7", "done single cycle", 64'(agu_done), 64'h0);
        exp_ea_q.delete();
        exp_el_q.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < MAX_VL; i++)
            idx_vec[i] = 64'h0000_0000_0001_0000 * 64'(i) + 64'h0000_1234_8000_80F0 - 64'(i * 3);
        idx_vec[2] = 64'hFFFF_FFFF_FFFF_FFF8;
        repeat (3) @(negedge clk);
        check(!agu_valid && !agu_done, "R1", "reset outputs",
              {62'h0, agu_valid, agu_done}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!agu_valid && !agu_done, "R1", "idle after reset",
              {62'h0, agu_valid, agu_done}, 64'h0);

        run_op("R2", 0, 0, 0, 2'b00, 2'b00, 5, 64'h1000, 64'h20, 0);
        run_op("R2", 0, 0, 0, 2'b00, 2'b01, 4, 64'h2000, 64'h4, 0);
        run_op("R2", 0, 0, 0, 2'b00, 2'b10, 3, 64'h3000, 64'h0, 0);
        run_op("R2", 0, 0, 0, 2'b11, 2'b11, 6, 64'h4001, 64'h3, 0);
        run_op("R3", 0, 1, 0, 2'b01, 2'b00, 4, 64'h1_0000, 64'hFFFF_FFFF_8000_0010, 0);
        run_op("R3", 0, 1, 1, 2'b11, 2'b00, 5, 64'h5000, 64'h0000_0000_0000_01F0, 0);
        run_op("R3", 0, 1, 0, 2'b00, 2'b00, 3, 64'h6000, 64'h0000_0001_0000_0000, 0);
        rdy_always = 1'b0;
        run_op("R4", 1, 0, 1, 2'b10, 2'b00, 8, 64'h8000_0000_0000_0000, 64'h0, 0);
        run_op("R4", 1, 0, 0, 2'b10, 2'b00, 8, 64'h8000_0000_0000_0000, 64'h0, 0);
        run_op("R4", 1, 1, 1, 2'b11, 2'b00, 6, 64'h100, 64'h0, 0);
        run_op("R4", 1, 0, 1, 2'b00, 2'b00, 4, 64'h10, 64'h0, 0);
        run_op("R5", 1, 0, 0, 2'b11, 2'b00, 3, 64'hFFFF_0000_1234_5678, 64'h0, 0);
        run_op("R5", 0, 1, 0, 2'b11, 2'b00, 3, 64'hABCD_EF00_0000_0000, 64'h1_0008, 0);
        rdy_always = 1'b1;
        run_op("R8", 0, 0, 0, 2'b00, 2'b00, 0, 64'h7000, 64'h0, 0);
        run_op("R9", 0, 0, 0, 2'b00, 2'b00, 13, 64'h9000, 64'h8, 0);
        run_op("R10", 0, 0, 0, 2'b00, 2'b01, 5, 64'hA000, 64'h40, 1);
        rdy_always = 1'b0;
        run_op("R6", 0, 1, 0, 2'b10, 2'b00, 7, 64'hB000, 64'h30, 0);
        repeat (2) @(negedge clk);
        summary();
        $finish;
    end
endmodule